// File: doc/BRIEF.md
# Per-Frame Error Flag Serializer

This block takes the status flags that the error corrector and the interpolator produce for each decoded audio frame and sends them out one after another on a single flag line. A frame strobe loads a fresh set of flags. The first slot of every sequence carries the absolute-time sync. That sync is the subcode sync pulse seen after the FIFO, so it lines up with the audio leaving the block. The remaining slots carry the status vector.

Each slot lasts three time units. A set flag shows as a high pulse during the first unit of its slot, and the line stays low for the other two units. The unit length is one parameter counted in clock cycles. When insertion is enabled, the flag of the slot in progress replaces bit 0 of a 24-bit audio-interface word that passes through the block.

Top module: `ffs_flag_serializer`

## Requirements
- R1: After reset `flag_line` is low, no sequence runs and the inserted flag bit is 0, until the first frame strobe.
- R2: On a frame strobe the block latches `status` and the pending sync. Changes on `status` between strobes have no effect on the sequence in progress.
- R3: The sequence has eight slots. Slot 0 carries the sync, and slot k (1..7) carries `status[k-1]`. Slot k starts 3*UNIT_CYC*k clock cycles after the strobe edge. A set flag makes `flag_line` high for exactly UNIT_CYC cycles at the start of its slot.
- R4: `flag_line` is low in the last 2*UNIT_CYC cycles of every slot, and it is low for the whole of any slot whose flag is clear.
- R5: A `sync_in` pulse at any time since the previous strobe, including the cycle of the strobe itself, sets the slot 0 flag of the next latched set. Each strobe consumes the pending sync, so a frame with no new pulse has slot 0 clear.
- R6: After slot 7 the sequence returns to slot 0 and repeats with the same latched flags until the next strobe.
- R7: A strobe that arrives in the middle of a sequence restarts it at slot 0 with the new flags on the next edge.
- R8: With `ins_en` high, `aud_out` equals `aud_in` with bit 0 replaced by the flag of the current slot. That flag is held for the whole slot, not only during the pulse.
- R9: With `ins_en` low, `aud_out` equals `aud_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle frame strobe; latches flags and starts a sequence |
| sync_in | input | 1 | Subcode sync pulse after the FIFO |
| status | input | NSTAT (7) | Corrector and interpolator status for slots 1..7 |
| ins_en | input | 1 | Enables flag insertion into bit 0 of the audio word |
| aud_in | input | AUD_W (24) | Audio-interface word in |
| flag_line | output | 1 | Serial flag output |
| aud_out | output | AUD_W (24) | Audio-interface word out |

## Verification
Every cycle, the embedded assertions check these properties:
- the unit counter stays in range;
- phase and slot hold while a unit is counting;
- a strobe restarts the sequence at slot 0;
- slot 7 wraps to slot 0;
- the latched flags stay unchanged between strobes;
- the pending sync is captured and then consumed;
- the line stays quiet while idle.

Only the bench scenarios show that each slot's pulse appears at the right cycle with the right content. They also cover the following:
- status noise during a sequence is ignored;
- a sync arriving on the strobe cycle reaches slot 0;
- the inserted audio bit follows the held slot flag.

// File: rtl/ffs_pkg.sv
package ffs_pkg;

    // Three units per slot: one pulse unit followed by two quiet units.
    typedef enum logic [1:0] {
        PH_PULSE = 2'd0,
        PH_GAP1  = 2'd1,
        PH_GAP2  = 2'd2
    } phase_e;

    localparam int AUD_W_DEF = 24;

endpackage

// File: rtl/ffs_flag_latch.sv
module ffs_flag_latch #(
    parameter  int NSTAT = 7,
    localparam int NSLOT = NSTAT + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             sync_in,
    input  logic [NSTAT-1:0] status,
    output logic [NSLOT-1:0] flags
);

    typedef struct packed {
        logic [NSLOT-1:0] flags;
        logic             sync_pend;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_stb) begin
            st_d.flags     = {status, st_q.sync_pend | sync_in};
            st_d.sync_pend = 1'b0;
        end else if (sync_in) begin
            st_d.sync_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    // R2: latched flags only change on a strobe
    a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(flags));

    // R5: a strobe consumes the pending sync
    a_r5_sync_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !st_q.sync_pend);

    // R5: a sync outside the strobe cycle is remembered
    a_r5_sync_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && !frame_stb) |=> st_q.sync_pend);

endmodule

// File: rtl/ffs_slot_timer.sv
module ffs_slot_timer
    import ffs_pkg::*;
#(
    parameter  int UNIT_CYC = 8,
    parameter  int NSLOT    = 8,
    localparam int CNT_W    = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1,
    localparam int SLOT_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    output logic              run,
    output logic [SLOT_W-1:0] slot,
    output logic              in_pulse
);

    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(UNIT_CYC - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NSLOT - 1);

    typedef struct packed {
        logic              run;
        phase_e            ph;
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  cnt;
    } tim_t;

    tim_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_stb) begin
            st_d.run  = 1'b1;
            st_d.ph   = PH_PULSE;
            st_d.slot = '0;
            st_d.cnt  = '0;
        end else if (st_q.run) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.cnt = '0;
                unique case (st_q.ph)
                    PH_PULSE: st_d.ph = PH_GAP1;
                    PH_GAP1:  st_d.ph = PH_GAP2;
                    default: begin
                        st_d.ph   = PH_PULSE;
                        st_d.slot = (st_q.slot == SLOT_LAST) ? '0 : st_q.slot + 1'b1;
                    end
                endcase
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{run: 1'b0, ph: PH_PULSE, slot: '0, cnt: '0};
        else        st_q <= st_d;
    end

    assign run      = st_q.run;
    assign slot     = st_q.slot;
    assign in_pulse = st_q.run && (st_q.ph == PH_PULSE);

    // R3: unit counter never leaves its range
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LAST);

    // R3: phase and slot hold while a unit is still counting
    a_r3_unit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !frame_stb && st_q.cnt != CNT_LAST)
            |=> ($stable(st_q.ph) && $stable(st_q.slot)));

    // R7: a strobe restarts at the first slot
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (run && slot == '0 && st_q.ph == PH_PULSE && st_q.cnt == '0));

    // R6: the last slot wraps back to the first
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !frame_stb && st_q.slot == SLOT_LAST &&
         st_q.ph == PH_GAP2 && st_q.cnt == CNT_LAST) |=> (slot == '0 && in_pulse));

endmodule

// File: rtl/ffs_lsb_insert.sv
module ffs_lsb_insert #(
    parameter int AUD_W = 24
) (
    input  logic             ins_en,
    input  logic             cur_flag,
    input  logic [AUD_W-1:0] aud_in,
    output logic [AUD_W-1:0] aud_out
);

    always_comb begin
        aud_out = aud_in;
        if (ins_en) aud_out[0] = cur_flag;
    end

endmodule

// File: rtl/ffs_flag_serializer.sv
module ffs_flag_serializer #(
    parameter  int UNIT_CYC = 8,
    parameter  int NSTAT    = 7,
    parameter  int AUD_W    = ffs_pkg::AUD_W_DEF,
    localparam int NSLOT    = NSTAT + 1,
    localparam int SLOT_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             sync_in,
    input  logic [NSTAT-1:0] status,
    input  logic             ins_en,
    input  logic [AUD_W-1:0] aud_in,
    output logic             flag_line,
    output logic [AUD_W-1:0] aud_out
);

    logic [NSLOT-1:0]  flags;
    logic              run;
    logic [SLOT_W-1:0] slot;
    logic              in_pulse;
    logic              cur_flag;

    ffs_flag_latch #(.NSTAT(NSTAT)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_stb(frame_stb),
        .sync_in  (sync_in),
        .status   (status),
        .flags    (flags)
    );

    ffs_slot_timer #(.UNIT_CYC(UNIT_CYC), .NSLOT(NSLOT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_stb(frame_stb),
        .run      (run),
        .slot     (slot),
        .in_pulse (in_pulse)
    );

    assign cur_flag  = run && flags[slot];
    assign flag_line = in_pulse && cur_flag;

    ffs_lsb_insert #(.AUD_W(AUD_W)) u_ins (
        .ins_en  (ins_en),
        .cur_flag(cur_flag),
        .aud_in  (aud_in),
        .aud_out (aud_out)
    );

    // R1/R4: the line is quiet when no sequence runs
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !flag_line);

    // R8: no inserted flag while idle
    a_r8_idle_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && ins_en) |-> !aud_out[0]);

endmodule

// File: tb/ffs_flag_serializer_bench.sv
module ffs_flag_serializer_bench;

    localparam int U     = 3;
    localparam int NSTAT = 7;
    localparam int AW    = 24;
    localparam int SEQ   = 8 * 3 * U;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_stb = 1'b0;
    logic             sync_in = 1'b0;
    logic [NSTAT-1:0] status = '0;
    logic             ins_en = 1'b0;
    logic [AW-1:0]    aud_in = '0;
    logic             flag_line;
    logic [AW-1:0]    aud_out;

    always #5 clk = ~clk;

    ffs_flag_serializer #(.UNIT_CYC(U), .NSTAT(NSTAT), .AUD_W(AW)) u_ffs_flag_serializer (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sync_in(sync_in),
        .status(status), .ins_en(ins_en), .aud_in(aud_in),
        .flag_line(flag_line), .aud_out(aud_out)
    );

    typedef struct {
        logic          line;
        logic [AW-1:0] aud;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    bit   pend   = 0;

    // monitor: compare one expected item per sampled cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (flag_line !== e.line || aud_out !== e.aud) begin
                fails++;
                $display("FAIL %s: line=%b aud=%h expected line=%b aud=%h",
                         e.tag, flag_line, aud_out, e.line, e.aud);
            end
        end
    end

    task automatic push_exp(input logic ln, input logic cur, input string tag);
        exp_t e;
        e.line = ln;
        e.aud  = ins_en ? {aud_in[AW-1:1], cur} : aud_in;
        e.tag  = tag;
        q.push_back(e);
    endtask

    // idle cycles before any frame: line low, inserted bit 0
    task automatic idle(input int n, input bit sync_at0);
        for (int i = 0; i < n; i++) begin
            ins_en  = 1'($urandom);
            aud_in  = AW'($urandom);
            sync_in = sync_at0 && (i == 0);
            if (sync_in) pend = 1;
            push_exp(1'b0, 1'b0, "R1 R8 R9 idle");
            @(posedge clk); #1;
        end
        sync_in = 1'b0;
    endtask

    // strobe a frame, then check n cycles of the sequence
    task automatic frame(input logic [NSTAT-1:0] st, input logic sy,
                         input int n, input int sync_at, input string tag);
        logic [7:0] fl;
        frame_stb = 1'b1;
        status    = st;
        sync_in   = sy;
        fl        = {st, pend | sy};
        pend      = 0;
        @(posedge clk); #1;
        frame_stb = 1'b0;
        sync_in   = 1'b0;
        for (int i = 0; i < n; i++) begin
            int u;
            int sl;
            int ph;
            u  = i / U;
            sl = (u / 3) % 8;
            ph = u % 3;
            status  = NSTAT'($urandom);   // R2: noise after latch
            ins_en  = 1'($urandom);
            aud_in  = AW'($urandom);
            sync_in = (i == sync_at);
            if (sync_in) pend = 1;
            push_exp((ph == 0) && fl[sl], fl[sl], tag);
            @(posedge clk); #1;
        end
        sync_in = 1'b0;
    endtask

    initial begin
        // R1: during and after reset
        @(posedge clk); #1;
        ins_en = 1'b1; aud_in = 24'hABCDEF;
        push_exp(1'b0, 1'b0, "R1 in reset");
        @(posedge clk); #1;
        push_exp(1'b0, 1'b0, "R1 in reset");
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(6, 1'b0);
        // R5: sync while idle lands in slot 0 of the next frame
        idle(4, 1'b1);
        // R2 R3 R4 R6 R8 R9: full sequence plus wrap
        frame(7'b1010011, 1'b0, SEQ + 30, -1, "R2 R3 R4 R5 R6 R8 R9 frame A");
        // R5: sync consumed, all clear -> line always low
        frame(7'b0000000, 1'b0, SEQ, -1, "R4 R5 clear frame");
        // R5: sync on strobe cycle; R7: cut short then restarted
        frame(7'b1111111, 1'b1, 40, 20, "R3 R5 R7 frame C");
        frame(7'b0100101, 1'b0, SEQ + 10, -1, "R5 R7 R6 restart frame");
        frame(7'b1000001, 1'b0, 2 * SEQ, -1, "R3 R6 R8 frame E");
        @(posedge clk); #1;
        @(posedge clk); #1;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule